// File: doc/BRIEF.md
# Chainable Sequential Configuration Stream Reader

This block reads a byte-wide configuration array in strict address order, paced by an external clock. Each rising clock edge moves an internal position counter forward by one step, and the location that position names is presented on the data pins until the next edge. The consumer can therefore capture each value on the edge that follows. In serial mode the array is sent one bit at a time on lane 0, with the most significant bit of each byte first. In parallel mode a whole byte goes out on all eight lanes on each clock. The output lanes are modelled as a value vector plus one drive-enable per lane. A disabled lane is taken as high impedance.

An active-low chip enable and an active-low output-enable/reset gate the counter and the drivers. When the counter steps past its last position, the block stops driving, freezes the counter, and pulls its chain-enable output low. That output is wired to the chip enable of a second instance, so the second instance starts streaming from its location 0 on the same edge. Two or more instances on a shared clock and shared data lanes thus deliver one unbroken bitstream. Serial or parallel operation is held in a one-bit control register. The register is serial after reset and is written through a control strobe.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `ce_n` is low, `oe_rst_n` is high and the end has not been passed, each rising `clk` edge advances the stream by exactly one position (one bit in serial mode, one byte in parallel mode).
- R2: While `oe_rst_n` is low, all lane enables are 0, the position returns to location 0 at the next edge, and `ceo_n` is high.
- R3: While `ce_n` is high, all lane enables are 0, `ceo_n` is high, `standby` is 1, and the position returns to location 0 at the next edge.
- R4: Once the final position has been presented, the next edge moves past it. From then on the position stays frozen, all lane enables are 0 and `ceo_n` is low, for as long as `ce_n` stays low and `oe_rst_n` stays high.
- R5: `ceo_n` is low only when `ce_n` is low, `oe_rst_n` is high and the end has been passed. Pulling `oe_rst_n` low drives `ceo_n` high in that same cycle, and it stays high until `oe_rst_n` returns high and the stream is walked past its end again.
- R6: In serial mode (mode bit 0) only lane 0 is enabled (`dout_en` = 8'h01). Lane 0 carries byte k bit (7 - j) at stream position 8k + j, so each byte goes out MSB first.
- R7: In parallel mode (mode bit 1) all lanes are enabled (`dout_en` = 8'hFF) and `dout` carries array byte k at stream position k.
- R8: After `rst` the mode bit is 0 (serial). A cycle with `cfg_we` high loads `cfg_par` into the mode bit at that edge.
- R9: When the block becomes enabled, location 0 appears in the same cycle, before any counting edge. Location k appears after the k-th counting edge.
- R10: With `ceo_n` of one instance feeding `ce_n` of the next, at most one instance enables any lane in any cycle. The second instance presents its location 0 in the cycle right after the first instance presents its last position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stream clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset (position, end flag, mode) |
| ce_n | input | 1 | Active-low chip enable; high means standby |
| oe_rst_n | input | 1 | Active-low output disable and position reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_par | input | 1 | Mode value written by `cfg_we`: 0 serial, 1 parallel |
| ld_we | input | 1 | Array preload write enable |
| ld_addr | input | $clog2(DEPTH) | Array preload byte address |
| ld_data | input | 8 | Array preload byte |
| dout | output | 8 | Lane values |
| dout_en | output | 8 | Per-lane drive enables (0 = high impedance) |
| ceo_n | output | 1 | Active-low chain enable to the next instance |
| standby | output | 1 | High while the chip enable is deasserted |

## Verification
Two instances are chained, and a behavioural position model predicts on every clock which instance drives, which lanes it drives, the value on those lanes, and both chain-enable outputs. The hand-off edge is the sharpest corner. A block that released its lanes one cycle late would collide with its successor. A block that wrapped its counter instead of saturating would replay byte 0 over the second instance's data. The bench also pulls the output-enable low while the chain sits past its end, and toggles the chip enable mid-stream. A chain-enable that was registered instead of tracking the reset input would hold low too long. A hold that did not clear the position would resume mid-array rather than at location 0. The mode is switched both ways, so a serial path that sent LSB first or enabled extra lanes would show up as wrong data or as stray enables.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;
  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_PAR = 1'b1
  } rd_mode_e;

  localparam int LANES = 8;
endpackage

// File: rtl/cfg_rd_array.sv
module cfg_rd_array #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cfg_rd_seq.sv
module cfg_rd_seq
  import cfg_rd_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce_n,
  input  logic                       oe_rst_n,
  input  rd_mode_e                   mode,
  output logic [$clog2(DEPTH)+2:0]   pos,
  output logic                       past_end,
  output logic [$clog2(DEPTH)-1:0]   fetch_addr,
  output logic [2:0]                 bit_sel
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 3;
  localparam logic [CW-1:0] LAST_PAR = CW'(DEPTH - 1);
  localparam logic [CW-1:0] LAST_SER = CW'(DEPTH * 8 - 1);

  logic          run;
  logic [CW-1:0] last_pos;
  logic          at_last;
  logic [CW-1:0] pos_nxt;
  logic          past_nxt;

  assign run      = !ce_n && oe_rst_n;
  assign last_pos = (mode == MODE_PAR) ? LAST_PAR : LAST_SER;
  assign at_last  = (pos == last_pos);

  always_comb begin
    if (rst || !run) begin
      pos_nxt  = '0;
      past_nxt = 1'b0;
    end else if (past_end || at_last) begin
      pos_nxt  = pos;
      past_nxt = 1'b1;
    end else begin
      pos_nxt  = pos + CW'(1);
      past_nxt = 1'b0;
    end
  end

  // Read-ahead: fetch the byte for the position taking effect at this edge.
  assign fetch_addr = (mode == MODE_PAR) ? pos_nxt[AW-1:0] : pos_nxt[AW+2:3];
  assign bit_sel    = pos[2:0];

  always_ff @(posedge clk) begin
    pos      <= pos_nxt;
    past_end <= past_nxt;
  end

  // R2 / R3: a hold returns the position to location 0
  a_r3_hold_clears: assert property (@(posedge clk) disable iff (rst)
    (ce_n || !oe_rst_n) |=> (pos == '0 && !past_end));

  // R1: one step per enabled edge until the end
  a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
    (run && !past_end && !at_last) |=> (pos == $past(pos) + CW'(1) && !past_end));

  // R4: beyond the end the position is frozen
  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    (run && (past_end || at_last)) |=> (past_end && $stable(pos)));
endmodule

// File: rtl/cfg_rd_drive.sv
module cfg_rd_drive
  import cfg_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             oe_rst_n,
  input  logic             past_end,
  input  rd_mode_e         mode,
  input  logic [2:0]       bit_sel,
  input  logic [LANES-1:0] cur_byte,
  output logic [LANES-1:0] dout,
  output logic [LANES-1:0] dout_en,
  output logic             ceo_n,
  output logic             standby
);
  logic active;

  assign active  = !ce_n && oe_rst_n && !past_end;
  assign ceo_n   = !(!ce_n && oe_rst_n && past_end);
  assign standby = ce_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_ser
      assign dout[g]    = (mode == MODE_PAR) ? cur_byte[g] : cur_byte[3'd7 - bit_sel];
      assign dout_en[g] = active;
    end else begin : g_par
      assign dout[g]    = (mode == MODE_PAR) ? cur_byte[g] : 1'b0;
      assign dout_en[g] = active && (mode == MODE_PAR);
    end
  end

  // R4: no lane driven once the end is passed
  a_r4_released: assert property (@(posedge clk) disable iff (rst)
    past_end |-> (dout_en == '0));

  // R5: chain enable only after the end
  a_r5_chain_qualified: assert property (@(posedge clk) disable iff (rst)
    !ceo_n |-> (past_end && dout_en == '0));

  // R6: serial mode uses lane 0 only
  a_r6_one_lane: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SER) |-> ($countones(dout_en) <= 1 && dout_en[LANES-1:1] == '0));

  // R7: parallel mode drives all lanes or none
  a_r7_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PAR) |-> ($countones(dout_en) == 0 || $countones(dout_en) == LANES));
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfg_rd_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce_n,
  input  logic                     oe_rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_par,
  input  logic                     ld_we,
  input  logic [$clog2(DEPTH)-1:0] ld_addr,
  input  logic [7:0]               ld_data,
  output logic [7:0]               dout,
  output logic [7:0]               dout_en,
  output logic                     ceo_n,
  output logic                     standby
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 3;

  rd_mode_e          mode_q;
  logic [CW-1:0]     pos;
  logic              past_end;
  logic [AW-1:0]     fetch_addr;
  logic [2:0]        bit_sel;
  logic [LANES-1:0]  cur_byte;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_SER;
    else if (cfg_we) mode_q <= rd_mode_e'(cfg_par);
  end

  // R8: mode is serial right after reset
  a_r8_serial_default: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_q == MODE_SER));

  cfg_rd_seq #(.DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .oe_rst_n   (oe_rst_n),
    .mode       (mode_q),
    .pos        (pos),
    .past_end   (past_end),
    .fetch_addr (fetch_addr),
    .bit_sel    (bit_sel)
  );

  cfg_rd_array #(.DEPTH(DEPTH), .DW(LANES)) u_array (
    .clk     (clk),
    .wr_en   (ld_we),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (fetch_addr),
    .rd_data (cur_byte)
  );

  cfg_rd_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_rst_n (oe_rst_n),
    .past_end (past_end),
    .mode     (mode_q),
    .bit_sel  (bit_sel),
    .cur_byte (cur_byte),
    .dout     (dout),
    .dout_en  (dout_en),
    .ceo_n    (ceo_n),
    .standby  (standby)
  );
endmodule

// File: tb/cfg_stream_reader_bench.sv
module cfg_stream_reader_bench;
  localparam int D  = 8;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_rst_n = 1'b1, cfg_we = 1'b0, cfg_par = 1'b0;
  logic ld_we_a = 1'b0, ld_we_b = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] dout_a, en_a, dout_b, en_b;
  logic ceo_a, ceo_b, stby_a, stby_b;

  int checks = 0, failures = 0;
  int pos = 0;
  bit par = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_stream_reader #(.DEPTH(D)) u_cfg_stream_reader (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_rst_n(oe_rst_n),
    .cfg_we(cfg_we), .cfg_par(cfg_par), .ld_we(ld_we_a), .ld_addr(ld_addr),
    .ld_data(ld_data), .dout(dout_a), .dout_en(en_a), .ceo_n(ceo_a), .standby(stby_a));

  cfg_stream_reader #(.DEPTH(D)) u_cfg_stream_reader_nxt (
    .clk(clk), .rst(rst), .ce_n(ceo_a), .oe_rst_n(oe_rst_n),
    .cfg_we(cfg_we), .cfg_par(cfg_par), .ld_we(ld_we_b), .ld_addr(ld_addr),
    .ld_data(ld_data), .dout(dout_b), .dout_en(en_b), .ceo_n(ceo_b), .standby(stby_b));

  function automatic logic [7:0] pat(int inst, int i);
    return 8'(((i * 29) + (inst * 113) + 7) ^ (i << 3));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (pos=%0d par=%0d)", tag, act, exp, pos, par);
    end
  endtask

  // Compare the chained pair against the position model.
  task automatic compare();
    int n = par ? D : 8 * D;
    bit ena = !ce_n && oe_rst_n;
    bit drv_a = ena && pos < n;
    bit drv_b = ena && pos >= n && pos < 2 * n;
    logic [7:0] lanes = par ? 8'hFF : 8'h01;
    string tag;
    if (!oe_rst_n) tag = "R2";
    else if (ce_n) tag = "R3";
    else if (pos >= 2 * n) tag = "R4";
    else if (pos >= n) tag = "R10";
    else tag = par ? "R1 R7" : "R1 R6";
    chk(tag, en_a, drv_a ? lanes : 8'h00);
    chk(tag, en_b, drv_b ? lanes : 8'h00);
    chk("R5", ceo_a, !(ena && pos >= n));
    chk("R5", ceo_b, !(ena && pos >= 2 * n));
    chk("R3", stby_a, ce_n);
    chk("R10", (en_a != 0) && (en_b != 0), 0);
    if (drv_a || drv_b) begin
      int g = par ? pos : pos / 8;
      logic [7:0] byt = (g < D) ? pat(0, g) : pat(1, g - D);
      logic [7:0] bus = drv_a ? dout_a : dout_b;
      if (par) chk(tag, bus, byt);
      else     chk(tag, bus[0], byt[7 - (pos % 8)]);
    end
  endtask

  task automatic cyc(logic ce, logic oe, logic cw = 1'b0, logic cp = 1'b0, bit first = 1'b0);
    int n;
    @(negedge clk);
    ce_n = ce; oe_rst_n = oe; cfg_we = cw; cfg_par = cp;
    #1;
    compare();
    if (first) begin
      chk("R8", en_a, 8'h01);
      chk("R9", dout_a[0], pat(0, 0) >> 7);
    end
    @(posedge clk);
    n = par ? D : 8 * D;
    if (ce || !oe) pos = 0;
    else if (pos < 2 * n) pos++;
    if (cw) par = cp;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      @(negedge clk);
      ld_we_a = 1'b1; ld_we_b = 1'b0; ld_addr = AW'(i); ld_data = pat(0, i);
      @(negedge clk);
      ld_we_a = 1'b0; ld_we_b = 1'b1; ld_data = pat(1, i);
    end
    @(negedge clk);
    ld_we_a = 1'b0; ld_we_b = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R3", en_a | en_b, 8'h00);
    chk("R3", ceo_a, 1'b1);
    chk("R3", stby_a, 1'b1);
    cyc(1, 1);
    cyc(1, 1);
    // serial pass through both instances and beyond the end
    cyc(0, 1, 0, 0, 1);
    for (int i = 0; i < 16 * D + 5; i++) cyc(0, 1);
    // reset input while past the end
    for (int i = 0; i < 3; i++) cyc(0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 1);
    // chip enable high mid-stream
    cyc(1, 1);
    cyc(1, 1, 1, 1);
    cyc(1, 1);
    // parallel pass
    for (int i = 0; i < 2 * D + 4; i++) cyc(0, 1);
    cyc(0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1);
    cyc(1, 1, 1, 0);
    cyc(1, 1);
    for (int i = 0; i < 12; i++) cyc(0, 1);
    cyc(1, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule